// File: doc/BRIEF.md
# Panel Power and Register Sequencer

This block powers a small LCD panel up and down and programs its control registers over a write-only serial link. It drives the panel supply enable and an active-low panel reset. Every register write goes out as a single 16-bit frame. Start and stop strobes launch fixed, timed power-up and power-down scripts. While the panel is on and nothing else is running, the host can request three runtime updates: rewrite the mirror register, reload and rewrite the whole gamma curve, or change the resolution mode.

The block holds its own copies of the mode, the mirror flags and the twelve 10-bit gamma points, so a later power-up replays the latest settings. Millisecond waits come from a tick counter derived from the `CLK_HZ` parameter. A bench can therefore shorten them by giving a small clock frequency.

Top module: `panel_seq_top`

## Requirements
- R1: After reset the supply enable is low, the panel reset is low (asserted), chip select is high, serial clock is low, and both busy and powered are low. Stored settings reset to mode 7, both mirror flags clear, and gamma points 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023.
- R2: A start strobe while unpowered and idle raises the supply enable at once and holds reset low for 160 ms. It then releases reset and sends 20 frames in this order: register 2, register 3 = 0xDF, register 0x20 = 0xF0, register 0x21 = 0xF0, register 4, then registers 0x11 through 0x1F. Powered rises when the last frame ends.
- R3: A frame is 16 bits, MSB first. The serial clock idles low and data is stable at each rising edge. Bits 15:10 hold the register address, bit 9 is 0, bit 8 is 1 and bits 7:0 hold the data. Chip select is low for exactly 16 rising clock edges and high for at least one serial clock period between frames.
- R4: Register 2 data is 0x08 OR the stored 3-bit mode.
- R5: Register 4 data is 0x17, with bit 0 cleared when the stored horizontal mirror flag is set and bit 1 cleared when the stored vertical mirror flag is set. A mirror request latches both mirror inputs and sends only a register 4 frame.
- R6: Gamma bits 9:8 are packed four points per register: points 0-3 into 0x11, 4-7 into 0x12 and 8-11 into 0x13. Within each register the lowest-numbered point goes in bits 7:6, then 5:4, 3:2 and 1:0. Bits 7:0 of point k go to register 0x14+k.
- R7: A gamma request latches all twelve input points and sends the 15 gamma frames (0x11..0x1F). The latched curve is used at every later power-up.
- R8: A stop strobe while powered and idle first sends register 3 = 0xD8, then asserts reset. It waits at least 50 ms, sends register 3 = 0xD0, and then drops the supply enable and powered.
- R9: A start strobe while powered, or a stop strobe while unpowered, sends no frame and leaves all outputs unchanged.
- R10: A mode request with a 4-bit value above 7 is ignored. A valid value is stored. If the panel is powered, one register 2 frame carrying the new mode is sent at once.
- R11: Mirror and gamma requests are ignored unless the block is powered and idle. An ignored gamma request does not change the stored curve.
- R12: Busy is high from the cycle after a sequence is accepted until its last frame ends. Requests arriving while busy are ignored. In one cycle a start or stop strobe takes precedence over mode, mirror and gamma requests, and mode takes precedence over mirror, which takes precedence over gamma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Power-up strobe |
| stop_i | input | 1 | Power-down strobe |
| mode_req_i | input | 1 | Mode update strobe |
| mode_i | input | 4 | Requested mode; values above 7 are rejected |
| mirror_req_i | input | 1 | Mirror update strobe |
| hmirror_i | input | 1 | Horizontal mirror flag |
| vmirror_i | input | 1 | Vertical mirror flag |
| gamma_req_i | input | 1 | Gamma update strobe |
| gamma_i | input | 120 | Twelve 10-bit points, point k in bits 10k+9:10k |
| vcc_en_o | output | 1 | Panel supply enable |
| panel_rst_no | output | 1 | Panel reset, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | A sequence is in progress |
| powered_o | output | 1 | Panel is up and configured |

## Verification
Two pairs of functions can fall in the same cycle. A stop strobe and a gamma request can arrive together while the panel is powered and idle. A mirror request can arrive during the power-up wait. The bench drives the stop and gamma strobes in one cycle. It then expects exactly the two power-down frames, with the stored curve unchanged, and this is confirmed by the gamma frames replayed at the next power-up. It also pulses a mirror request while power-up is busy and expects register 4 to keep its earlier value.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  localparam int NPTS = 12;
  localparam int PW   = 10;
  localparam int GW   = NPTS * PW;

  localparam int ON_WAIT_MS  = 160;
  localparam int OFF_WAIT_MS = 50;
  localparam int ON_LAST     = 19;   // index of last power-up frame
  localparam int GAM_FIRST   = 5;

  localparam logic [5:0] A_MODE = 6'h02;
  localparam logic [5:0] A_PWR  = 6'h03;
  localparam logic [5:0] A_MIR  = 6'h04;
  localparam logic [5:0] A_HI   = 6'h11;
  localparam logic [5:0] A_LO   = 6'h14;
  localparam logic [5:0] A_DRV0 = 6'h20;
  localparam logic [5:0] A_DRV1 = 6'h21;

  localparam logic [7:0] D_PWR_ON   = 8'hDF;
  localparam logic [7:0] D_PWR_STBY = 8'hD8;
  localparam logic [7:0] D_PWR_OFF  = 8'hD0;
  localparam logic [7:0] D_DRV      = 8'hF0;
  localparam logic [7:0] D_MIR_BASE = 8'h17;
  localparam logic [7:0] D_MODE_BIT = 8'h08;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_ON, S_SEND, S_WAIT_OFF} seq_st_e;

  function automatic logic [15:0] mk_frame(logic [5:0] a, logic [7:0] d);
    return {a, 1'b0, 1'b1, d};
  endfunction

  function automatic logic [GW-1:0] gamma_init();
    logic [GW-1:0] g;
    g = '0;
    g[0*PW +: PW] = 10'd105;  g[1*PW +: PW]  = 10'd315;
    g[2*PW +: PW] = 10'd381;  g[3*PW +: PW]  = 10'd431;
    g[4*PW +: PW] = 10'd490;  g[5*PW +: PW]  = 10'd537;
    g[6*PW +: PW] = 10'd579;  g[7*PW +: PW]  = 10'd686;
    g[8*PW +: PW] = 10'd780;  g[9*PW +: PW]  = 10'd837;
    g[10*PW +: PW] = 10'd880; g[11*PW +: PW] = 10'd1023;
    return g;
  endfunction
endpackage

// File: rtl/panel_ms_timer.sv
module panel_ms_timer #(
  parameter int TICKS_PER_MS = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] ms_i,
  output logic       done_o
);
  localparam int TW = $clog2(TICKS_PER_MS + 1);

  logic [TW-1:0] tick_q;
  logic [7:0]    ms_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      ms_q   <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        run_q  <= 1'b1;
        ms_q   <= ms_i;
        tick_q <= '0;
      end else if (run_q) begin
        if (tick_q == TW'(TICKS_PER_MS - 1)) begin
          tick_q <= '0;
          if (ms_q <= 8'd1) begin
            run_q  <= 1'b0;
            done_o <= 1'b1;
          end else begin
            ms_q <= ms_q - 8'd1;
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/panel_spi_tx.sv
module panel_spi_tx #(
  parameter int HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic [15:0] word_i,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  output logic        done_o
);
  localparam int CW = $clog2(2 * HALF + 1);

  typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_GAP} tx_st_e;

  tx_st_e        st_q;
  logic [15:0]   sh_q;
  logic [3:0]    bit_q;
  logic [CW-1:0] cnt_q;

  assign mosi_o = sh_q[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      sclk_o <= 1'b0;
      cs_no  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        T_IDLE: if (go_i) begin
          sh_q  <= word_i;
          cs_no <= 1'b0;
          cnt_q <= '0;
          bit_q <= '0;
          st_q  <= T_SHIFT;
        end
        T_SHIFT: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
            end else begin
              sclk_o <= 1'b0;
              if (bit_q == 4'd15) begin
                cs_no <= 1'b1;
                st_q  <= T_GAP;
              end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= {sh_q[14:0], 1'b0};
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        T_GAP: begin
          if (cnt_q == CW'(2 * HALF - 1)) begin
            cnt_q  <= '0;
            st_q   <= T_IDLE;
            done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_frame_rom.sv
module panel_frame_rom
  import panel_seq_pkg::*;
(
  input  logic [4:0]    idx_i,
  input  logic          off_i,
  input  logic          off_stage_i,
  input  logic [2:0]    mode_i,
  input  logic          hmir_i,
  input  logic          vmir_i,
  input  logic [GW-1:0] gamma_i,
  output logic [15:0]   word_o
);
  logic [5:0] addr;
  logic [7:0] data;

  always_comb begin
    addr = A_MODE;
    data = D_MODE_BIT | {5'd0, mode_i};
    if (off_i) begin
      addr = A_PWR;
      data = off_stage_i ? D_PWR_OFF : D_PWR_STBY;
    end else begin
      case (idx_i)
        5'd1: begin addr = A_PWR;  data = D_PWR_ON; end
        5'd2: begin addr = A_DRV0; data = D_DRV; end
        5'd3: begin addr = A_DRV1; data = D_DRV; end
        5'd4: begin
          addr = A_MIR;
          data = D_MIR_BASE & ~{6'd0, vmir_i, hmir_i};
        end
        default: begin
          for (int g = 0; g < 3; g++) begin
            if (idx_i == 5'(GAM_FIRST + g)) begin
              addr = A_HI + 6'(g);
              for (int j = 0; j < 4; j++)
                data[7-2*j -: 2] = gamma_i[(4*g + j)*PW + 8 +: 2];
            end
          end
          for (int n = 0; n < NPTS; n++) begin
            if (idx_i == 5'(GAM_FIRST + 3 + n)) begin
              addr = A_LO + 6'(n);
              data = gamma_i[n*PW +: 8];
            end
          end
        end
      endcase
    end
  end

  assign word_o = mk_frame(addr, data);
endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
  import panel_seq_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SCLK_HALF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          mode_req_i,
  input  logic [3:0]    mode_i,
  input  logic          mirror_req_i,
  input  logic          hmirror_i,
  input  logic          vmirror_i,
  input  logic          gamma_req_i,
  input  logic [GW-1:0] gamma_i,
  output logic          vcc_en_o,
  output logic          panel_rst_no,
  output logic          spi_sclk_o,
  output logic          spi_cs_no,
  output logic          spi_mosi_o,
  output logic          busy_o,
  output logic          powered_o
);
  localparam int TPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  seq_st_e       st_q;
  logic [4:0]    idx_q, last_q;
  logic          off_q, off_stage_q;
  logic [2:0]    mode_q;
  logic          hmir_q, vmir_q;
  logic [GW-1:0] gamma_q;
  logic          tx_go_q, tim_go_q;
  logic [7:0]    tim_ms_q;
  logic          tx_done, tim_done;
  logic [15:0]   word;

  panel_frame_rom u_rom (
    .idx_i(idx_q), .off_i(off_q), .off_stage_i(off_stage_q),
    .mode_i(mode_q), .hmir_i(hmir_q), .vmir_i(vmir_q),
    .gamma_i(gamma_q), .word_o(word)
  );

  panel_spi_tx #(.HALF(SCLK_HALF)) u_tx (
    .clk_i, .rst_ni, .go_i(tx_go_q), .word_i(word),
    .sclk_o(spi_sclk_o), .cs_no(spi_cs_no), .mosi_o(spi_mosi_o),
    .done_o(tx_done)
  );

  panel_ms_timer #(.TICKS_PER_MS(TPM)) u_tim (
    .clk_i, .rst_ni, .go_i(tim_go_q), .ms_i(tim_ms_q), .done_o(tim_done)
  );

  assign busy_o = (st_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      idx_q        <= '0;
      last_q       <= '0;
      off_q        <= 1'b0;
      off_stage_q  <= 1'b0;
      mode_q       <= 3'd7;
      hmir_q       <= 1'b0;
      vmir_q       <= 1'b0;
      gamma_q      <= gamma_init();
      tx_go_q      <= 1'b0;
      tim_go_q     <= 1'b0;
      tim_ms_q     <= '0;
      vcc_en_o     <= 1'b0;
      panel_rst_no <= 1'b0;
      powered_o    <= 1'b0;
    end else begin
      tx_go_q  <= 1'b0;
      tim_go_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (start_i && !powered_o) begin
            vcc_en_o <= 1'b1;
            tim_go_q <= 1'b1;
            tim_ms_q <= 8'(ON_WAIT_MS);
            st_q     <= S_WAIT_ON;
          end else if (stop_i && powered_o) begin
            off_q       <= 1'b1;
            off_stage_q <= 1'b0;
            tx_go_q     <= 1'b1;
            st_q        <= S_SEND;
          end else if (mode_req_i && !mode_i[3]) begin
            mode_q <= mode_i[2:0];
            if (powered_o) begin
              idx_q   <= 5'd0;
              last_q  <= 5'd0;
              tx_go_q <= 1'b1;
              st_q    <= S_SEND;
            end
          end else if (mirror_req_i && powered_o) begin
            hmir_q  <= hmirror_i;
            vmir_q  <= vmirror_i;
            idx_q   <= 5'd4;
            last_q  <= 5'd4;
            tx_go_q <= 1'b1;
            st_q    <= S_SEND;
          end else if (gamma_req_i && powered_o) begin
            gamma_q <= gamma_i;
            idx_q   <= 5'(GAM_FIRST);
            last_q  <= 5'(ON_LAST);
            tx_go_q <= 1'b1;
            st_q    <= S_SEND;
          end
        end
        S_WAIT_ON: if (tim_done) begin
          panel_rst_no <= 1'b1;
          idx_q        <= 5'd0;
          last_q       <= 5'(ON_LAST);
          tx_go_q      <= 1'b1;
          st_q         <= S_SEND;
        end
        S_SEND: if (tx_done) begin
          if (off_q && !off_stage_q) begin
            panel_rst_no <= 1'b0;
            tim_go_q     <= 1'b1;
            tim_ms_q     <= 8'(OFF_WAIT_MS);
            st_q         <= S_WAIT_OFF;
          end else if (off_q) begin
            off_q     <= 1'b0;
            vcc_en_o  <= 1'b0;
            powered_o <= 1'b0;
            st_q      <= S_IDLE;
          end else if (idx_q == last_q) begin
            powered_o <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            tx_go_q <= 1'b1;
          end
        end
        S_WAIT_OFF: if (tim_done) begin
          off_stage_q <= 1'b1;
          tx_go_q     <= 1'b1;
          st_q        <= S_SEND;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic mode_req_i,
  input logic mirror_req_i,
  input logic gamma_req_i,
  input logic vcc_en_o,
  input logic panel_rst_no,
  input logic spi_sclk_o,
  input logic spi_cs_no,
  input logic busy_o,
  input logic powered_o
);
  logic [5:0] edge_cnt;
  logic       sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= spi_sclk_o;
      if (spi_cs_no) edge_cnt <= '0;
      else if (spi_sclk_o && !sclk_d) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assert_rst_under_supply_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_en_o |-> !panel_rst_no);

  assert_powered_has_supply_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    powered_o |-> vcc_en_o);

  assert_sclk_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  assert_frame_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> (edge_cnt == 6'd16));

  assert_cs_only_when_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> spi_cs_no);

  assert_stop_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !powered_o && stop_i && !start_i) |=> !busy_o);

  assert_start_when_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && powered_o && start_i && !stop_i && !mode_req_i && !mirror_req_i
     && !gamma_req_i) |=> !busy_o);

  assert_req_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !powered_o && !start_i) |=> !busy_o);
endmodule

bind panel_seq_top panel_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .mode_req_i(mode_req_i), .mirror_req_i(mirror_req_i),
  .gamma_req_i(gamma_req_i), .vcc_en_o(vcc_en_o),
  .panel_rst_no(panel_rst_no), .spi_sclk_o(spi_sclk_o),
  .spi_cs_no(spi_cs_no), .busy_o(busy_o), .powered_o(powered_o)
);

// File: tb/sim_panel_seq_top.sv
`timescale 1ns/1ps
module sim_panel_seq_top;
  localparam int HZ   = 4000;   // 4 ticks per ms
  localparam int TPM  = 4;
  localparam int HALF = 2;

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, mode_req = 0, mirror_req = 0, gamma_req = 0;
  logic hmir = 0, vmir = 0;
  logic [3:0] mode = 0;
  logic [119:0] gam = '0;
  logic vcc, prst_n, sclk, cs_n, mosi, busy, pwr;

  always #10 clk = ~clk;

  panel_seq_top #(.CLK_HZ(HZ), .SCLK_HALF(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .mode_req_i(mode_req), .mode_i(mode), .mirror_req_i(mirror_req),
    .hmirror_i(hmir), .vmirror_i(vmir), .gamma_req_i(gamma_req),
    .gamma_i(gam), .vcc_en_o(vcc), .panel_rst_no(prst_n),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi),
    .busy_o(busy), .powered_o(pwr)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [15:0] fr [0:63];
  int fb [0:63];
  int nfr = 0, bc = 0, min_gap = 1000000, last_up = -1000000;
  logic [15:0] sh = 0;
  logic sclk_d = 0, cs_d = 1, vcc_d = 0, prst_d = 0;
  int t_vcc_up = 0, t_rst_up = 0, t_rst_dn = 0, t_vcc_dn = 0;

  // model copies of stored settings
  int m_mode = 7;
  logic m_h = 0, m_v = 0;
  int m_g [12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && sclk && !sclk_d) begin sh = {sh[14:0], mosi}; bc++; end
    if (!cs_n && cs_d) begin
      if (cyc - last_up < min_gap) min_gap = cyc - last_up;
      bc = 0;
    end
    if (cs_n && !cs_d) begin
      if (nfr < 64) begin fr[nfr] = sh; fb[nfr] = bc; end
      nfr++;
      last_up = cyc;
    end
    if (vcc && !vcc_d) t_vcc_up = cyc;
    if (!vcc && vcc_d) t_vcc_dn = cyc;
    if (prst_n && !prst_d) t_rst_up = cyc;
    if (!prst_n && prst_d) t_rst_dn = cyc;
    sclk_d = sclk; cs_d = cs_n; vcc_d = vcc; prst_d = prst_n;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int frm(int a, int d);
    return (a << 10) | 'h100 | (d & 'hff);
  endfunction

  function automatic int gam_word(int k);  // k = 0..14 within gamma block
    int d = 0;
    if (k < 3) begin
      for (int j = 0; j < 4; j++) d |= ((m_g[4*k+j] >> 8) & 3) << (6 - 2*j);
      return frm('h11 + k, d);
    end
    return frm('h14 + k - 3, m_g[k-3] & 'hff);
  endfunction

  function automatic int mir_word();
    int d = 'h17;
    if (m_h) d &= ~1;
    if (m_v) d &= ~2;
    return frm(4, d);
  endfunction

  function automatic int on_word(int i);
    case (i)
      0: return frm(2, 8 | m_mode);
      1: return frm(3, 'hDF);
      2: return frm('h20, 'hF0);
      3: return frm('h21, 'hF0);
      4: return mir_word();
      default: return gam_word(i - 5);
    endcase
  endfunction

  task automatic clr();
    nfr = 0; min_gap = 1000000;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 40000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic check_frames(string req, int n, int base_kind);
    // base_kind: 0 power-up list, 1 gamma block
    chk(req, "frame count", nfr, n);
    for (int i = 0; i < n && i < nfr; i++) begin
      chk(req, $sformatf("frame %0d", i), fr[i], base_kind ? gam_word(i) : on_word(i));
      chk("R3", $sformatf("frame %0d bits", i), fb[i], 16);
    end
  endtask

  task automatic t_reset();
    chk("R1", "vcc", vcc, 0);
    chk("R1", "rst_n", prst_n, 0);
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "sclk", sclk, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "powered", pwr, 0);
  endtask

  task automatic t_idle_noops_off();
    clr();
    pulse(stop);                   // R9 stop while off
    chk("R9", "busy after stop off", busy, 0);
    mode = 4'd9; pulse(mode_req);  // R10 invalid mode
    hmir = 1; pulse(mirror_req);   // R11 mirror while off
    gam = {12{10'h3ff}}; pulse(gamma_req);  // R11 gamma while off
    repeat (20) @(negedge clk);
    chk("R11", "frames while off", nfr, 0);
    chk("R9", "vcc while off", vcc, 0);
    hmir = 0;
  endtask

  task automatic t_power_up(string tag);
    clr();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk("R2", "vcc at start", vcc, 1);
    chk("R12", "busy at start", busy, 1);
    chk("R2", "rst held", prst_n, 0);
    // mirror request during busy must be dropped (R12)
    @(negedge clk); hmir = ~m_h; vmir = ~m_v; mirror_req = 1;
    @(negedge clk); mirror_req = 0;
    wait_idle();
    n_chk++;
    if (t_rst_up - t_vcc_up < 160*TPM || t_rst_up - t_vcc_up > 160*TPM + 6) begin
      n_bad++;
      $display("FAIL R2 %s reset delay: got %0d expected %0d..%0d", tag,
               t_rst_up - t_vcc_up, 160*TPM, 160*TPM + 6);
    end
    check_frames("R2", 20, 0);
    chk("R3", "min cs gap >= sclk period", (min_gap >= 2*HALF) ? 1 : 0, 1);
    chk("R2", "powered", pwr, 1);
    chk("R2", "rst released", prst_n, 1);
  endtask

  task automatic t_start_on();
    clr();
    pulse(start);
    repeat (10) @(negedge clk);
    chk("R9", "frames on re-start", nfr, 0);
    chk("R9", "busy on re-start", busy, 0);
  endtask

  task automatic t_mirror(logic h, logic v);
    clr();
    hmir = h; vmir = v; pulse(mirror_req);
    m_h = h; m_v = v;
    wait_idle();
    chk("R5", "mirror frames", nfr, 1);
    chk("R5", "reg4 frame", fr[0], mir_word());
  endtask

  task automatic t_gamma();
    clr();
    for (int k = 0; k < 12; k++) begin
      m_g[k] = (k * 97 + 300) % 1024;
      gam[k*10 +: 10] = 10'(m_g[k]);
    end
    pulse(gamma_req);
    wait_idle();
    check_frames("R7", 15, 1);
  endtask

  task automatic t_mode();
    clr();
    mode = 4'd3; pulse(mode_req);
    m_mode = 3;
    wait_idle();
    chk("R10", "mode frames", nfr, 1);
    chk("R4", "reg2 frame", fr[0], frm(2, 'h0B));
    clr();
    mode = 4'd12; pulse(mode_req);
    repeat (10) @(negedge clk);
    chk("R10", "invalid mode frames", nfr, 0);
  endtask

  task automatic t_stop_with_gamma();
    clr();
    gam = '0;                      // would zero the curve if taken
    @(negedge clk); stop = 1; gamma_req = 1;
    @(negedge clk); stop = 0; gamma_req = 0;
    wait_idle();
    chk("R12", "off frames only", nfr, 2);
    chk("R8", "first off frame", fr[0], frm(3, 'hD8));
    chk("R8", "second off frame", fr[1], frm(3, 'hD0));
    chk("R8", "rst low", prst_n, 0);
    chk("R8", "vcc low", vcc, 0);
    chk("R8", "powered low", pwr, 0);
    chk("R8", "rst before vcc off", (t_rst_dn < t_vcc_dn) ? 1 : 0, 1);
    chk("R8", "off wait >= 50ms", (t_vcc_dn - t_rst_dn >= 50*TPM) ? 1 : 0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_idle_noops_off();
    t_power_up("first");          // default mode 7, default gamma (R4, R6)
    t_start_on();
    t_mirror(1, 0);
    t_mirror(1, 1);
    t_gamma();
    t_mode();
    t_stop_with_gamma();
    t_power_up("second");          // replays mode 3, mirror, new gamma (R7)
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule